// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block runs one SD-card command at a time for a host register interface. Software writes a 32-bit argument and then an 11-bit command word. The command word holds an index, a flag that asks for a response, a flag that asks for a long response, a pending flag and an enable flag. When the enable flag is set, the block offers the index and argument to a card-side responder through a valid/ready request channel.

The responder answers with a header that carries a byte count and an error flag. After the header it sends response bytes, one per valid cycle. The block checks the byte count against the response the command asked for. It packs accepted bytes into four 32-bit response words, most significant byte first. It then sets exactly one sticky status flag: command sent, response received, or timeout. The serial command-line bit protocol and CRC generation sit outside this block.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A command word written with bit 10 (enable) set and bit 9 (pending) clear causes `req_valid_o` to rise on the next cycle. `req_index_o` then carries bits 5:0 of the word and `req_arg_o` carries the last argument written. Bit 6 requests a response and bit 7 requests a long response.
- R2: If bit 6 is clear and the card reports no error, status bit 7 (sent) is set and the response words keep their previous values.
- R3: Status bit 2 (timeout) is set and the response words keep their values in any of these cases: the card reports an error; bit 6 is set and the returned byte count is neither 4 nor 16; or the count is 4 while bit 7 is set. Bytes that the block is not collecting are ignored.
- R4: A 4-byte response sets status bit 6 (response received). The first byte lands in bits 31:24 of word 0 and the fourth byte in bits 7:0, and words 1 to 3 read zero.
- R5: A 16-byte response sets status bit 6 and fills words 0 to 3, four bytes each, most significant byte first. Bit 0 of word 3 reads zero whatever the last byte was.
- R6: Once a command finishes, whether it succeeded or failed, bit 10 of `cmd_o` reads zero and `busy_o` is low. All other command bits are kept.
- R7: A command word with bits 10 and 9 both set issues no request and changes no status flag. It is stored with bit 10 cleared.
- R8: Status flags are sticky and build up across commands. A pulse on `clr_i` clears the flags whose `clr_mask_i` bits are set, and no others. Status bits other than 2, 6 and 7 read zero.
- R9: While `busy_o` is high, writes to the command word and the argument are ignored.
- R10: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o` stays high and the index and argument stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 11 | Command word write data |
| arg_wr_i | input | 1 | Argument write strobe |
| arg_wdata_i | input | 32 | Argument write data |
| clr_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 8 | Status bits to clear |
| cmd_o | output | 11 | Stored command word |
| arg_o | output | 32 | Stored argument |
| status_o | output | 8 | Sticky status flags |
| resp_o | output | 128 | Response words; word k is at bits 32k+31:32k |
| busy_o | output | 1 | Command in progress |
| req_valid_o | output | 1 | Request offered to the card |
| req_ready_i | input | 1 | Card accepts the request |
| req_index_o | output | 6 | Command index |
| req_arg_o | output | 32 | Command argument |
| rsp_valid_i | input | 1 | Response header valid |
| rsp_ready_o | output | 1 | Block waits for a header |
| rsp_len_i | input | 5 | Response byte count |
| rsp_err_i | input | 1 | Card error |
| byte_valid_i | input | 1 | Response byte valid |
| byte_i | input | 8 | Response byte |

## Verification
Commands with no response, short responses and long responses show which of the three completion flags is chosen. Rejected lengths (0, 4 against a long request, odd counts) and card errors show that the length check and the error path are separate from byte collection. Random byte values in both response sizes expose lane or word swaps and the forced low bit of word 3. Pending commands, writes made mid-command and partial clears show that stored state is kept and that the flags are sticky bit by bit.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int CMD_W   = 11;
  localparam int IDX_W   = 6;
  localparam int B_RESP  = 6;
  localparam int B_LONG  = 7;
  localparam int B_PEND  = 9;
  localparam int B_EN    = 10;
  localparam int STAT_W  = 8;
  localparam int S_TMO   = 2;
  localparam int S_RESP  = 6;
  localparam int S_SENT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_SHIFT, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic              arg_wr_i,
  input  logic [ARG_W-1:0]  arg_wdata_i,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              set_tmo_i,
  input  logic              set_resp_i,
  input  logic              set_sent_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ARG_W-1:0]  arg_o,
  output logic [STAT_W-1:0] status_o,
  output logic              start_o
);
  logic [CMD_W-1:0] cmd_q;
  logic [ARG_W-1:0] arg_q;
  logic tmo_q, resp_q, sent_q;
  logic wr_ok, hold_pend;

  assign wr_ok     = cmd_wr_i && !busy_i;
  assign hold_pend = cmd_wdata_i[B_EN] && cmd_wdata_i[B_PEND];
  assign start_o   = wr_ok && cmd_wdata_i[B_EN] && !cmd_wdata_i[B_PEND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      arg_q <= '0;
    end else begin
      if (wr_ok) begin
        cmd_q <= cmd_wdata_i;
        if (hold_pend) cmd_q[B_EN] <= 1'b0;
      end else if (done_i) begin
        cmd_q[B_EN] <= 1'b0;
      end
      if (arg_wr_i && !busy_i) arg_q <= arg_wdata_i;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= 1'b0;
      resp_q <= 1'b0;
      sent_q <= 1'b0;
    end else begin
      tmo_q  <= set_tmo_i  || (tmo_q  && !(clr_i && clr_mask_i[S_TMO]));
      resp_q <= set_resp_i || (resp_q && !(clr_i && clr_mask_i[S_RESP]));
      sent_q <= set_sent_i || (sent_q && !(clr_i && clr_mask_i[S_SENT]));
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[S_TMO]  = tmo_q;
    status_o[S_RESP] = resp_q;
    status_o[S_SENT] = sent_q;
  end

  assign cmd_o = cmd_q;
  assign arg_o = arg_q;

  p_en_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !cmd_q[B_EN]);
  p_pend_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_i && hold_pend) |=> (!cmd_q[B_EN] && !busy_i));
  p_arg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(arg_q));
  p_one_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_tmo_i, set_resp_i, set_sent_i}));
endmodule

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
  import sd_cmd_pkg::*;
#(
  parameter int LEN_W      = 5,
  parameter int RESP_WORDS = 4,
  localparam int LONG_BYTES  = RESP_WORDS * 4,
  localparam int SHORT_BYTES = 4,
  localparam int BCNT_W      = $clog2(LONG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              resp_exp_i,
  input  logic              long_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic [LEN_W-1:0]  rsp_len_i,
  input  logic              rsp_err_i,
  input  logic              byte_valid_i,
  output logic              req_valid_o,
  output logic              rsp_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              set_tmo_o,
  output logic              set_resp_o,
  output logic              set_sent_o,
  output logic              st_clr_o,
  output logic              st_we_o,
  output logic [BCNT_W-1:0] st_idx_o,
  output logic              st_mask_o
);
  seq_state_e state_q, state_d;
  logic [BCNT_W-1:0] cnt_q, last_q;
  logic full_q;
  logic is_short, is_long, bad, hdr;

  assign is_short = rsp_len_i == LEN_W'(SHORT_BYTES);
  assign is_long  = rsp_len_i == LEN_W'(LONG_BYTES);
  assign bad      = rsp_err_i ||
                    (resp_exp_i && (!(is_short || is_long) || (is_short && long_i)));
  assign hdr      = (state_q == ST_WAIT) && rsp_valid_i;

  assign req_valid_o = state_q == ST_ISSUE;
  assign rsp_ready_o = state_q == ST_WAIT;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign set_tmo_o   = hdr && bad;
  assign set_sent_o  = hdr && !bad && !resp_exp_i;
  assign st_clr_o    = hdr && !bad && resp_exp_i;
  assign st_we_o     = (state_q == ST_SHIFT) && byte_valid_i;
  assign st_idx_o    = cnt_q;
  assign st_mask_o   = full_q;
  assign set_resp_o  = st_we_o && (cnt_q == last_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid_i) state_d = st_clr_o ? ST_SHIFT : ST_DONE;
      ST_SHIFT: if (set_resp_o) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (st_clr_o) begin
        cnt_q  <= '0;
        last_q <= rsp_len_i[BCNT_W-1:0] - BCNT_W'(1);
        full_q <= is_long;
      end else if (st_we_o) begin
        cnt_q <= cnt_q + BCNT_W'(1);
      end
    end
  end

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> req_valid_o);
endmodule

// File: rtl/sd_resp_store.sv
module sd_resp_store #(
  parameter int RESP_WORDS = 4,
  localparam int LONG_BYTES = RESP_WORDS * 4,
  localparam int BCNT_W     = $clog2(LONG_BYTES),
  localparam int WSEL_W     = BCNT_W - 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    we_i,
  input  logic [BCNT_W-1:0]       idx_i,
  input  logic [7:0]              byte_i,
  input  logic                    mask_i,
  output logic [RESP_WORDS*32-1:0] resp_o
);
  logic [31:0] word_q [RESP_WORDS];
  logic [7:0]  byte_in;
  logic [1:0]  lane;
  logic        last_byte;

  assign last_byte = idx_i == BCNT_W'(LONG_BYTES - 1);
  assign byte_in   = (mask_i && last_byte) ? {byte_i[7:1], 1'b0} : byte_i;
  assign lane      = 2'd3 - idx_i[1:0];  // first byte of a word is the MSB

  for (genvar w = 0; w < RESP_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[w] <= '0;
      else if (clr_i) word_q[w] <= '0;
      else if (we_i && idx_i[BCNT_W-1:2] == WSEL_W'(w))
        word_q[w][lane*8 +: 8] <= byte_in;
    end
    assign resp_o[w*32 +: 32] = word_q[w];
  end

  p_lsb_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mask_i && last_byte) |=> !word_q[RESP_WORDS-1][0]);
endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W      = 32,
  parameter int LEN_W      = 5,
  parameter int RESP_WORDS = 4,
  localparam int BCNT_W    = $clog2(RESP_WORDS * 4)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_wr_i,
  input  logic [CMD_W-1:0]         cmd_wdata_i,
  input  logic                     arg_wr_i,
  input  logic [ARG_W-1:0]         arg_wdata_i,
  input  logic                     clr_i,
  input  logic [STAT_W-1:0]        clr_mask_i,
  output logic [CMD_W-1:0]         cmd_o,
  output logic [ARG_W-1:0]         arg_o,
  output logic [STAT_W-1:0]        status_o,
  output logic [RESP_WORDS*32-1:0] resp_o,
  output logic                     busy_o,
  output logic                     req_valid_o,
  input  logic                     req_ready_i,
  output logic [IDX_W-1:0]         req_index_o,
  output logic [ARG_W-1:0]         req_arg_o,
  input  logic                     rsp_valid_i,
  output logic                     rsp_ready_o,
  input  logic [LEN_W-1:0]         rsp_len_i,
  input  logic                     rsp_err_i,
  input  logic                     byte_valid_i,
  input  logic [7:0]               byte_i
);
  logic start, done, set_tmo, set_resp, set_sent;
  logic st_clr, st_we, st_mask;
  logic [BCNT_W-1:0] st_idx;

  sd_cmd_regs #(.ARG_W(ARG_W)) u_regs (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_wdata_i, .arg_wr_i, .arg_wdata_i,
    .clr_i, .clr_mask_i,
    .busy_i(busy_o), .done_i(done),
    .set_tmo_i(set_tmo), .set_resp_i(set_resp), .set_sent_i(set_sent),
    .cmd_o, .arg_o, .status_o, .start_o(start)
  );

  sd_cmd_seq #(.LEN_W(LEN_W), .RESP_WORDS(RESP_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .resp_exp_i(cmd_o[B_RESP]), .long_i(cmd_o[B_LONG]),
    .req_ready_i, .rsp_valid_i, .rsp_len_i, .rsp_err_i, .byte_valid_i,
    .req_valid_o, .rsp_ready_o, .busy_o, .done_o(done),
    .set_tmo_o(set_tmo), .set_resp_o(set_resp), .set_sent_o(set_sent),
    .st_clr_o(st_clr), .st_we_o(st_we), .st_idx_o(st_idx), .st_mask_o(st_mask)
  );

  sd_resp_store #(.RESP_WORDS(RESP_WORDS)) u_store (
    .clk_i, .rst_ni,
    .clr_i(st_clr), .we_i(st_we), .idx_i(st_idx), .byte_i, .mask_i(st_mask),
    .resp_o
  );

  assign req_index_o = cmd_o[IDX_W-1:0];
  assign req_arg_o   = arg_o;

  p_req_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> ($stable(req_index_o) && $stable(req_arg_o)));
endmodule

// File: tb/sd_cmd_issuer_test.sv
module sd_cmd_issuer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_wr = 0, arg_wr = 0, clr = 0;
  logic [10:0] cmd_wdata = '0;
  logic [31:0] arg_wdata = '0;
  logic [7:0] clr_mask = '0;
  logic [10:0] cmd_o;
  logic [31:0] arg_o;
  logic [7:0] status_o;
  logic [127:0] resp_o;
  logic busy_o, req_valid_o, rsp_ready_o;
  logic req_ready = 0, rsp_valid = 0, rsp_err = 0, byte_valid = 0;
  logic [5:0] req_index_o;
  logic [31:0] req_arg_o;
  logic [4:0] rsp_len = '0;
  logic [7:0] byte_d = '0;

  sd_cmd_issuer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .arg_wr_i(arg_wr), .arg_wdata_i(arg_wdata),
    .clr_i(clr), .clr_mask_i(clr_mask),
    .cmd_o, .arg_o, .status_o, .resp_o, .busy_o,
    .req_valid_o, .req_ready_i(req_ready), .req_index_o, .req_arg_o,
    .rsp_valid_i(rsp_valid), .rsp_ready_o, .rsp_len_i(rsp_len), .rsp_err_i(rsp_err),
    .byte_valid_i(byte_valid), .byte_i(byte_d)
  );

  int checks = 0, fails = 0;
  logic [7:0]  exp_st = '0;
  logic [31:0] exp_w [4];
  logic [7:0]  bytes_q [32];

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_resp();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  task automatic clear(input logic [7:0] m);
    @(negedge clk); clr = 1; clr_mask = m;
    @(negedge clk); clr = 0; clr_mask = '0;
    exp_st = exp_st & ~m;
    check("R8 clear", status_o, exp_st);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit resp,
                         input bit lng, input bit pend, input int len, input bit err,
                         input bit intrude);
    logic [10:0] word;
    bit bad;
    string tag;
    word = {1'b1, pend, 1'b0, lng, resp, idx};
    for (int b = 0; b < 32; b++) bytes_q[b] = 8'($urandom);
    @(negedge clk); arg_wr = 1; arg_wdata = arg;
    @(negedge clk); arg_wr = 0; cmd_wr = 1; cmd_wdata = word;
    @(negedge clk); cmd_wr = 0;
    if (pend) begin
      check("R7 busy", {127'd0, busy_o}, 128'd0);
      check("R7 no request", {127'd0, req_valid_o}, 128'd0);
      check("R7 cmd stored", {117'd0, cmd_o}, {117'd0, word & 11'h3ff});
      check("R7 status", {120'd0, status_o}, {120'd0, exp_st});
      return;
    end
    check("R1 valid", {127'd0, req_valid_o}, 128'd1);
    check("R1 index", {122'd0, req_index_o}, {122'd0, idx});
    check("R1 arg", {96'd0, req_arg_o}, {96'd0, arg});
    repeat ($urandom % 3) @(negedge clk);
    check("R10 held", {90'd0, req_valid_o, req_index_o, req_arg_o}, {90'd0, 1'b1, idx, arg});
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    if (intrude) begin
      cmd_wr = 1; cmd_wdata = 11'h43f; arg_wr = 1; arg_wdata = 32'hdeadbeef;
      @(negedge clk); cmd_wr = 0; arg_wr = 0;
    end
    repeat ($urandom % 3) @(negedge clk);
    rsp_valid = 1; rsp_len = 5'(len); rsp_err = err;
    @(negedge clk); rsp_valid = 0; rsp_err = 0;
    if (!err) begin
      for (int b = 0; b < len; b++) begin
        repeat ($urandom % 2) @(negedge clk);
        byte_valid = 1; byte_d = bytes_q[b];
        @(negedge clk); byte_valid = 0;
      end
    end
    for (int t = 0; t < 50 && busy_o; t++) @(negedge clk);
    bad = err || (resp && ((len != 4 && len != 16) || (len == 4 && lng)));
    if (bad) begin exp_st[2] = 1'b1; tag = "R3"; end
    else if (!resp) begin exp_st[7] = 1'b1; tag = "R2"; end
    else begin
      exp_st[6] = 1'b1;
      tag = (len == 4) ? "R4" : "R5";
      for (int w = 0; w < 4; w++) exp_w[w] = '0;
      for (int b = 0; b < len; b++) exp_w[b/4][(3 - b%4)*8 +: 8] = bytes_q[b];
      if (len == 16) exp_w[3][0] = 1'b0;
    end
    check({tag, " status"}, {120'd0, status_o}, {120'd0, exp_st});
    check({tag, " response"}, resp_o, exp_resp());
    check("R6 enable cleared", {116'd0, busy_o, cmd_o}, {116'd0, 1'b0, word & 11'h3ff});
    if (intrude) check("R9 arg kept", {96'd0, arg_o}, {96'd0, arg});
  endtask

  task automatic run_all();
    void'($urandom(32'h5eed1234));
    for (int w = 0; w < 4; w++) exp_w[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset status", {120'd0, status_o}, 128'd0);
    check("R4 reset resp", resp_o, 128'd0);
    check("R6 reset idle", {115'd0, busy_o, req_valid_o, cmd_o}, 128'd0);
    // stray bytes while idle
    repeat (3) begin
      byte_valid = 1; byte_d = 8'hff; @(negedge clk);
    end
    byte_valid = 0;
    check("R3 idle bytes ignored", resp_o, 128'd0);

    run_cmd(6'd0, 32'h0, 0, 0, 0, 0, 0, 0);                 // R2
    run_cmd(6'd17, 32'h1234_5678, 1, 0, 0, 4, 0, 0);        // R4, flags accumulate
    check("R8 accumulate", {120'd0, status_o}, 128'hc0);
    repeat (3) @(negedge clk);
    check("R8 sticky", {120'd0, status_o}, 128'hc0);
    clear(8'h80);
    check("R8 partial", {120'd0, status_o}, 128'h40);
    clear(8'hff);
    run_cmd(6'd2, 32'h0, 1, 1, 0, 16, 0, 0);                // R5
    clear(8'hff);
    run_cmd(6'd9, 32'h1, 1, 1, 0, 4, 0, 0);                 // R3 long vs 4
    clear(8'hff);
    run_cmd(6'd3, 32'h2, 1, 0, 0, 0, 0, 0);                 // R3 zero length
    clear(8'hff);
    run_cmd(6'd5, 32'h3, 1, 0, 0, 7, 0, 0);                 // R3 odd length
    clear(8'hff);
    run_cmd(6'd8, 32'h4, 0, 0, 0, 0, 1, 0);                 // R3 error, no resp
    clear(8'hff);
    run_cmd(6'd12, 32'h5, 1, 0, 1, 4, 0, 0);                // R7
    run_cmd(6'd13, 32'hcafe_f00d, 1, 0, 0, 4, 0, 1);        // R9
    clear(8'hff);
    run_cmd(6'd41, 32'h6, 1, 0, 0, 16, 0, 0);               // R5 short req, 16 bytes
    clear(8'hff);
    for (int i = 0; i < 40; i++) begin
      int len, sel;
      sel = $urandom % 4;
      len = (sel == 0) ? 0 : (sel == 1) ? 4 : (sel == 2) ? 16 : int'($urandom % 21);
      run_cmd(6'($urandom), $urandom, 1'($urandom), 1'($urandom), ($urandom % 10) == 0,
              len, ($urandom % 8) == 0, 0);
      clear(8'hff);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule